// File: doc/BRIEF.md
# Host-register byte port to external nonvolatile memory

This block is a single 32-bit control/status register through which a host reaches a byte-wide external nonvolatile memory. Every access is built from steps written into the same register. A 3-bit command field in the top bits says what the 8-bit payload field carries: the low address byte, the high address byte, a data byte to store, or a request to fetch a byte. The top bit has two roles. On a write it starts a step. On a read it reports whether the previous step is still in progress.

The register also carries three write-one strobe bits. Each one gives a one-cycle clear pulse to a neighbouring block: the mailbox flags, the add-on-to-host FIFO flags and the host-to-add-on FIFO flags. It also carries a sticky bit that drives an add-on reset output, and a plain loop-back mode bit. The external memory is reached through a level request / one-cycle done handshake. The 16-bit address is formed from the two latched bytes.

Top module: `nvm_cmd_port`

## Requirements
- R1: After reset the register reads 0x00000000, `mem_req` is low, all three strobe outputs are low and `addon_rst` is low.
- R2: A write with bits 31:29 = 100 latches bits 23:16 as the low address byte. A write with 101 latches them as the high address byte. `mem_addr` is {high byte, low byte} and stays stable while `mem_req` is high.
- R3: After an accepted address-latch command, read-back bit 31 is 1 for exactly one cycle and then returns to 0.
- R4: A write with bits 31:29 = 110 loads bits 23:16 as the data byte and raises `mem_req` with `mem_we` = 1 and `mem_wdata` equal to that byte. Bit 31 reads 1 until the cycle after `mem_done` is sampled high, and `mem_req` falls at the same time.
- R5: A write with bits 31:29 = 111 raises `mem_req` with `mem_we` = 0. When `mem_done` is sampled high, `mem_rdata` is captured, and from then on bits 23:16 read back that byte.
- R6: A command written while bit 31 reads 1 is ignored: no address byte, data byte or new request changes.
- R7: A write with bit 31 = 0 starts no access and leaves the address bytes and the bits 23:16 read-back unchanged.
- R8: Writing 1 to bit 27, 26 or 25 gives a single-cycle pulse on `mbox_clr`, `a2h_fifo_clr` or `h2a_fifo_clr` respectively, in the cycle after the write. These bits always read 0. `a2h_fifo_clr` means: set that FIFO's empty flag and clear its full and four-plus flags. `h2a_fifo_clr` means: set empty, clear full, and set four-plus-available.
- R9: Bit 24 is read/write. It drives `addon_rst`, which stays at the written value until it is rewritten, whether or not the memory is busy.
- R10: Bit 28 is a read/write loop-back bit. Bits 30:29, 27:25 and 15:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the register |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Register read-back value |
| mem_req | output | 1 | Memory access request, held until done |
| mem_we | output | 1 | 1 = byte write, 0 = byte read (valid with `mem_req`) |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to store |
| mem_done | input | 1 | One-cycle completion from the memory |
| mem_rdata | input | 8 | Fetched byte, valid with `mem_done` |
| mbox_clr | output | 1 | Mailbox flag clear pulse |
| a2h_fifo_clr | output | 1 | Add-on-to-host FIFO flag clear pulse |
| h2a_fifo_clr | output | 1 | Host-to-add-on FIFO flag clear pulse |
| addon_rst | output | 1 | Add-on reset output |

## Verification
The hardest case to reach from the ports is a command that arrives while a memory transaction is still waiting for `mem_done`. The bench handles this by giving its memory model a fixed latency of several cycles. During that window it writes a conflicting address-latch command and a fresh read command, then checks that the address on the port and the later read-back did not move. It also combines the sticky and strobe bits with ignored commands in the same write. This shows that the register bits still take effect while the command is dropped.

// File: rtl/nvm_cmd_port.sv
module nvm_cmd_port #(
  parameter int BYTE_W = 8,
  parameter int REG_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic                mem_done,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                mbox_clr,
  output logic                a2h_fifo_clr,
  output logic                h2a_fifo_clr,
  output logic                addon_rst
);
  localparam int PAY_LO = 16;
  localparam logic [1:0] OP_LO = 2'b00, OP_HI = 2'b01, OP_WR = 2'b10, OP_RD = 2'b11;

  logic              busy, loop_q;
  logic [BYTE_W-1:0] lo_q, hi_q, byte_q;
  logic [BYTE_W-1:0] pay;
  logic [1:0]        op;
  logic              accept;

  assign pay    = wr_data[PAY_LO +: BYTE_W];
  assign op     = wr_data[30:29];
  assign accept = wr_en & wr_data[31] & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; mem_req <= 1'b0; mem_we <= 1'b0;
      lo_q <= '0; hi_q <= '0; byte_q <= '0;
      loop_q <= 1'b0; addon_rst <= 1'b0;
      mbox_clr <= 1'b0; a2h_fifo_clr <= 1'b0; h2a_fifo_clr <= 1'b0;
    end else begin
      mbox_clr     <= wr_en & wr_data[27];
      a2h_fifo_clr <= wr_en & wr_data[26];
      h2a_fifo_clr <= wr_en & wr_data[25];
      if (wr_en) begin
        loop_q    <= wr_data[28];
        addon_rst <= wr_data[24];
      end
      if (accept) begin
        busy <= 1'b1;
        case (op)
          OP_LO: lo_q <= pay;
          OP_HI: hi_q <= pay;
          OP_WR: begin byte_q <= pay; mem_req <= 1'b1; mem_we <= 1'b1; end
          default: begin mem_req <= 1'b1; mem_we <= 1'b0; end
        endcase
      end else if (busy && !mem_req) begin
        busy <= 1'b0;
      end else if (mem_req && mem_done) begin
        mem_req <= 1'b0;
        busy    <= 1'b0;
        if (!mem_we) byte_q <= mem_rdata;
      end
    end
  end

  assign mem_addr  = {hi_q, lo_q};
  assign mem_wdata = byte_q;
  assign rd_data   = {busy, 2'b00, loop_q, 3'b000, addon_rst, byte_q, {PAY_LO{1'b0}}};

  assert_req_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> rd_data[31]);
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));
  assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_done) |=> (!mem_req && !rd_data[31]));
  assert_latch_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && !mem_req) |=> !rd_data[31]);
  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && !(mem_req && mem_done)) |=> $stable(mem_addr));
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_clr && !(wr_en && wr_data[27])) |=> !mbox_clr);
  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[30:29] == 2'b00 && rd_data[27:25] == 3'b000 && rd_data[15:0] == 16'h0));
endmodule

// File: tb/nvm_cmd_port_bench.sv
module nvm_cmd_port_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mem_req, mem_we, mem_done = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic        mbox_clr, a2h_fifo_clr, h2a_fifo_clr, addon_rst;

  int n_cmp = 0, n_bad = 0;
  localparam int LAT = 4;

  always #10 clk = ~clk;

  nvm_cmd_port u_nvm_cmd_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .mem_rdata(mem_rdata), .mbox_clr(mbox_clr),
    .a2h_fifo_clr(a2h_fifo_clr), .h2a_fifo_clr(h2a_fifo_clr), .addon_rst(addon_rst));

  // external memory model
  logic [7:0] store [int];
  int lat_cnt = 0;
  always @(negedge clk) begin
    if (mem_done) mem_done <= 1'b0;
    else if (rst_n && mem_req) begin
      lat_cnt = lat_cnt + 1;
      if (lat_cnt == LAT) begin
        lat_cnt = 0;
        mem_done <= 1'b1;
        if (mem_we) store[int'(mem_addr)] = mem_wdata;
        else mem_rdata <= store.exists(int'(mem_addr)) ? store[int'(mem_addr)]
                                                       : (mem_addr[7:0] ^ mem_addr[15:8]);
      end
    end
  end

  // reference model
  bit       m_busy, m_req, m_we, m_loop, m_arst, m_mb, m_a2h, m_h2a;
  bit [7:0] m_lo, m_hi, m_byte;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_req = 0; m_we = 0; m_loop = 0; m_arst = 0;
      m_mb = 0; m_a2h = 0; m_h2a = 0; m_lo = 0; m_hi = 0; m_byte = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_mb = wr_en && wr_data[27]; m_a2h = wr_en && wr_data[26]; m_h2a = wr_en && wr_data[25];
      if (m_busy && m_req && mem_done) begin
        if (!m_we) m_byte = mem_rdata;
        m_req = 0; m_busy = 0;
      end else if (m_busy && !m_req) m_busy = 0;
      if (wr_en) begin
        m_loop = wr_data[28]; m_arst = wr_data[24];
        if (wr_data[31] && !was_busy) begin
          m_busy = 1;
          if (wr_data[30:29] == 2'd0) m_lo = wr_data[23:16];
          else if (wr_data[30:29] == 2'd1) m_hi = wr_data[23:16];
          else begin
            m_req = 1; m_we = !wr_data[29];
            if (m_we) m_byte = wr_data[23:16];
          end
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R10 rd_data", rd_data, {m_busy, 2'b00, m_loop, 3'b000, m_arst, m_byte, 16'h0});
    check("R4 mem_req", {31'h0, mem_req}, {31'h0, m_req});
    if (m_req) begin
      check("R2 mem_addr", {16'h0, mem_addr}, {16'h0, m_hi, m_lo});
      check("R5 mem_we", {31'h0, mem_we}, {31'h0, m_we});
      if (m_we) check("R4 mem_wdata", {24'h0, mem_wdata}, {24'h0, m_byte});
    end
    check("R8 strobes", {29'h0, mbox_clr, a2h_fifo_clr, h2a_fifo_clr}, {29'h0, m_mb, m_a2h, m_h2a});
    check("R9 addon_rst", {31'h0, addon_rst}, {31'h0, m_arst});
  end

  task automatic put(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 50 && rd_data[31]; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd(logic [2:0] c, logic [7:0] b);
    return {c, 5'b0, b, 16'h0};
  endfunction

  initial begin
    #1 check("R1 reset rd_data", rd_data, 32'h0);
    check("R1 reset outputs", {27'h0, mem_req, mbox_clr, a2h_fifo_clr, h2a_fifo_clr, addon_rst}, 32'h0);
    #44 rst_n = 1'b1;
    // R3 latch busy is one cycle
    @(negedge clk); wr_en = 1'b1; wr_data = cmd(3'b100, 8'h34);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R3 busy after latch", {31'h0, rd_data[31]}, 32'h1);
    @(negedge clk);
    check("R3 ready after one cycle", {31'h0, rd_data[31]}, 32'h0);
    put(cmd(3'b101, 8'h12)); wait_ready();
    // R4 byte write, then R6 commands while waiting
    put(cmd(3'b110, 8'hA5));
    put(cmd(3'b100, 8'hEE));
    put(cmd(3'b111, 8'h00) | 32'h0100_0000);
    check("R6 addr held while busy", {16'h0, mem_addr}, 32'h1234);
    wait_ready(); @(negedge clk);
    check("R4 stored byte", {24'h0, store[32'h1234]}, 32'hA5);
    check("R9 sticky set during busy", {31'h0, addon_rst}, 32'h1);
    // R7 inactive write leaves fields
    put(32'h00FF_0000);
    check("R7 payload unchanged", {24'h0, rd_data[23:16]}, 32'hA5);
    // R5 read back the written byte
    put(cmd(3'b111, 8'h00)); wait_ready();
    check("R5 read byte 1234", {24'h0, rd_data[23:16]}, 32'hA5);
    // R5 read unwritten location 0x5A3C -> 0x66
    put(cmd(3'b100, 8'h3C)); wait_ready();
    put(cmd(3'b101, 8'h5A)); wait_ready();
    put(cmd(3'b111, 8'h00)); wait_ready();
    check("R5 read byte 5A3C", {24'h0, rd_data[23:16]}, 32'h66);
    // R8 strobes, R10 loop bit
    put(32'h1E00_0000);
    check("R10 loop bit set", {31'h0, rd_data[28]}, 32'h1);
    put(32'h0800_0000); put(32'h0400_0000); put(32'h0200_0000);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h0E00_0000;
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h0E00_0000;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R8 back-to-back strobes", {29'h0, mbox_clr, a2h_fifo_clr, h2a_fifo_clr}, 32'h7);
    @(negedge clk);
    check("R8 strobes drop", {29'h0, mbox_clr, a2h_fifo_clr, h2a_fifo_clr}, 32'h0);
    // R9 clear add-on reset
    put(32'h0000_0000);
    check("R9 addon_rst cleared", {31'h0, addon_rst}, 32'h0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule